// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This peripheral lets two or more processors exchange 32-bit words through a small set of one-way queues. Each queue has one message port in the register space. A bus write to the port appends a word. A bus read from the same port returns the oldest word and removes it. Software can check two read-only registers per queue: a word count and a flag that is set when the queue cannot take another word.

Every processor, called a user here, has its own pair of interrupt registers, a status register and an enable register, and drives one interrupt line. Each queue owns two adjacent status bits. The lower bit records that a new message was accepted. The upper bit records that a read freed a slot in a queue that was full. Every user sees the same events, and each user enables the ones it cares about. A status bit is cleared by writing 1 to it.

A configuration register starts a short soft reset. The reset empties every queue and clears all interrupt state. A system status register reports when the reset is done, and a revision register identifies the block.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue count reads 0, every full flag reads 0, all interrupt status and enable registers read 0, every interrupt output is low, and bit 0 of the system status register (byte offset 0x014) reads 1.
- R2: A write to the message port of queue m (byte offset 0x040+4m) appends a word. A read from that port returns the oldest word and removes it, so words leave in the order they were written.
- R3: The count register of queue m (0x0C0+4m) reads the number of stored words, from 0 to the depth of 4. The full register of queue m (0x080+4m) reads 1 in bit 0 exactly when the count equals the depth, and reads 0 otherwise.
- R4: A write to the port of a full queue, with no read in the same cycle, is discarded and the contents stay the same. A read from the port of an empty queue returns 0 and the queue stays empty.
- R5: Every accepted write to queue m sets bit 2m in the interrupt status register of every user. User u's status register is at 0x100+8u.
- R6: A read that takes queue m from full to not full sets bit 2m+1 in every user's status register, unless a write to the same queue is accepted in that same cycle.
- R7: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Set bits stay set until they are cleared this way or by soft reset.
- R8: The interrupt enable register of user u is at 0x104+8u and uses the same bit layout as the status register. The interrupt output of user u is driven from a register. It goes high one cycle after any bit is set in both that user's status register and enable register, and goes low one cycle after no such bit remains.
- R9: Writing 1 to bit 1 of the configuration register (0x010) starts a soft reset that lasts 3 cycles. During the reset, configuration bit 1 reads 1 and system status bit 0 reads 0, and all register writes are ignored. When it ends, every queue is empty and all status and enable bits are 0. A configuration write with bit 1 at 0 has no effect.
- R10: When a read and a write to the same message port fall in the same cycle, the read returns the word that was oldest before that cycle, or 0 if the queue was empty. The write is accepted even if the queue was full, and the new-message bit is set.
- R11: The revision register (0x000) reads major number 1 in bits 7:4 and minor number 2 in bits 3:0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address shared by read and write |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; a read of a message port pops the queue |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq_out | output | 2 | Interrupt line of each user |

## Verification
The bus has a single address with independent read and write strobes. A read and a write can therefore hit the same message port in the same cycle, so a pop and a push land on one queue together. The bench provokes this on a full queue, where the write must still be accepted, the count must stay at the depth and no not-full event may appear. It also provokes it on an empty queue, where the read must return 0 and the word must still be stored. The reference model takes the pre-cycle queue contents to predict the read data, applies the pop before the push, and is compared with read data and both interrupt lines on every clock.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    // Word indices (byte offset / 4) of the register regions
    localparam int unsigned W_REV  = 0;
    localparam int unsigned W_CFG  = 4;
    localparam int unsigned W_SYS  = 5;
    localparam int unsigned W_MSG  = 16;
    localparam int unsigned W_FULL = 32;
    localparam int unsigned W_CNT  = 48;
    localparam int unsigned W_IRQ  = 64;

    localparam int unsigned CFG_SRST_BIT = 1;
    localparam int unsigned SYS_DONE_BIT = 0;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_REV,
        RG_CFG,
        RG_SYS,
        RG_MSG,
        RG_FULL,
        RG_CNT,
        RG_ISTAT,
        RG_IEN
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NQ = 4,
    parameter int NU = 2,
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);
    logic        unused_lsb;
    int unsigned wi;

    assign unused_lsb = ^addr[1:0];

    always_comb begin
        wi  = 32'(addr[AW-1:2]);
        sel = '{kind: RG_NONE, idx: 8'd0};
        if (wi == W_REV) begin
            sel.kind = RG_REV;
        end else if (wi == W_CFG) begin
            sel.kind = RG_CFG;
        end else if (wi == W_SYS) begin
            sel.kind = RG_SYS;
        end else if (wi >= W_MSG && wi < W_MSG + NQ) begin
            sel.kind = RG_MSG;
            sel.idx  = 8'(wi - W_MSG);
        end else if (wi >= W_FULL && wi < W_FULL + NQ) begin
            sel.kind = RG_FULL;
            sel.idx  = 8'(wi - W_FULL);
        end else if (wi >= W_CNT && wi < W_CNT + NQ) begin
            sel.kind = RG_CNT;
            sel.idx  = 8'(wi - W_CNT);
        end else if (wi >= W_IRQ && wi < W_IRQ + 2 * NU) begin
            sel.kind = wi[0] ? RG_IEN : RG_ISTAT;
            sel.idx  = 8'((wi - W_IRQ) >> 1);
        end
    end
endmodule

// File: rtl/mbox_queue.sv
`timescale 1ns/1ps
module mbox_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          ev_newmsg,
    output logic          ev_notfull
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic     pop_ok, push_ok, was_full;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d      = s_q;
        was_full = (s_q.cnt == CW'(DEPTH));
        pop_ok   = !flush && pop && (s_q.cnt != '0);
        push_ok  = !flush && push && (!was_full || pop_ok);
        if (flush) begin
            s_d.rp  = '0;
            s_d.wp  = '0;
            s_d.cnt = '0;
        end else begin
            if (push_ok) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp          = ptr_inc(s_q.wp);
            end
            if (pop_ok) begin
                s_d.rp = ptr_inc(s_q.rp);
            end
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head       = (s_q.cnt != '0) ? s_q.mem[s_q.rp] : '0;
    assign count      = s_q.cnt;
    assign full       = (s_q.cnt == CW'(DEPTH));
    assign ev_newmsg  = push_ok;
    assign ev_notfull = pop_ok && !push_ok && was_full;
endmodule

// File: rtl/mbox_user_irq.sv
`timescale 1ns/1ps
module mbox_user_irq #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [NEV-1:0] events,
    input  logic           ack_we,
    input  logic           en_we,
    input  logic [NEV-1:0] wdata,
    output logic [NEV-1:0] stat,
    output logic [NEV-1:0] en,
    output logic           irq
);
    typedef struct packed {
        logic [NEV-1:0] stat;
        logic [NEV-1:0] en;
        logic           irq;
    } irq_state_t;

    irq_state_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = |(r_q.stat & r_q.en);
        if (clear) begin
            r_d.stat = '0;
            r_d.en   = '0;
        end else begin
            r_d.stat = (r_q.stat & ~(ack_we ? wdata : '0)) | events;
            if (en_we) r_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.stat;
    assign en   = r_q.en;
    assign irq  = r_q.irq;
endmodule

// File: rtl/mbox_srst.sv
`timescale 1ns/1ps
module mbox_srst #(
    parameter int RST_LEN = 3,
    localparam int RW     = $clog2(RST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    typedef struct packed {
        logic [RW-1:0] cnt;
    } srst_state_t;

    srst_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.cnt != '0)  c_d.cnt = c_q.cnt - RW'(1);
        else if (start)     c_d.cnt = RW'(RST_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy = (c_q.cnt != '0);
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int NQ        = 4,
    parameter int DEPTH     = 4,
    parameter int DW        = 32,
    parameter int NU        = 2,
    parameter int AW        = 12,
    parameter int RST_LEN   = 3,
    parameter int REV_MAJOR = 1,
    parameter int REV_MINOR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr_en,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd_en,
    output logic [DW-1:0] bus_rdata,
    output logic [NU-1:0] irq_out
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int NEV = 2 * NQ;

    reg_sel_t                 sel;
    logic                     busy;
    logic                     srst_start;
    logic [NQ-1:0][DW-1:0]    q_head;
    logic [NQ-1:0][CW-1:0]    q_cnt;
    logic [NQ-1:0]            q_full;
    logic [NEV-1:0]           ev_vec;
    logic [NU-1:0][NEV-1:0]   ustat;
    logic [NU-1:0][NEV-1:0]   uen;

    mbox_decode #(.NQ(NQ), .NU(NU), .AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign srst_start = bus_wr_en && (sel.kind == RG_CFG) && bus_wdata[CFG_SRST_BIT];

    mbox_srst #(.RST_LEN(RST_LEN)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy)
    );

    for (genvar m = 0; m < NQ; m++) begin : g_queue
        logic hit;
        assign hit = (sel.kind == RG_MSG) && (sel.idx == 8'(m));
        mbox_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (busy),
            .push       (bus_wr_en && hit),
            .pop        (bus_rd_en && hit),
            .wdata      (bus_wdata),
            .head       (q_head[m]),
            .count      (q_cnt[m]),
            .full       (q_full[m]),
            .ev_newmsg  (ev_vec[2*m]),
            .ev_notfull (ev_vec[2*m+1])
        );
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        logic own;
        assign own = (sel.idx == 8'(u)) && bus_wr_en && !busy;
        mbox_user_irq #(.NEV(NEV)) u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (busy),
            .events (ev_vec),
            .ack_we (own && (sel.kind == RG_ISTAT)),
            .en_we  (own && (sel.kind == RG_IEN)),
            .wdata  (bus_wdata[NEV-1:0]),
            .stat   (ustat[u]),
            .en     (uen[u]),
            .irq    (irq_out[u])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            RG_REV: bus_rdata[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
            RG_CFG: bus_rdata[CFG_SRST_BIT] = busy;
            RG_SYS: bus_rdata[SYS_DONE_BIT] = !busy;
            RG_MSG: begin
                for (int m = 0; m < NQ; m++)
                    if (sel.idx == 8'(m)) bus_rdata = q_head[m];
            end
            RG_FULL: begin
                for (int m = 0; m < NQ; m++)
                    if (sel.idx == 8'(m)) bus_rdata[0] = q_full[m];
            end
            RG_CNT: begin
                for (int m = 0; m < NQ; m++)
                    if (sel.idx == 8'(m)) bus_rdata = DW'(q_cnt[m]);
            end
            RG_ISTAT: begin
                for (int u = 0; u < NU; u++)
                    if (sel.idx == 8'(u)) bus_rdata[NEV-1:0] = ustat[u];
            end
            RG_IEN: begin
                for (int u = 0; u < NU; u++)
                    if (sel.idx == 8'(u)) bus_rdata[NEV-1:0] = uen[u];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_checker.sv
`timescale 1ns/1ps
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DEPTH = 4,
    parameter int NU    = 2,
    parameter int AW    = 12,
    parameter int CW    = 3,
    parameter int NEV   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          addr,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic                   busy,
    input logic [NQ-1:0][CW-1:0]  q_cnt,
    input logic [NU-1:0][NEV-1:0] ustat,
    input logic [NU-1:0][NEV-1:0] uen,
    input logic [NU-1:0]          irq
);
    int unsigned wi;
    assign wi = 32'(addr[AW-1:2]);

    for (genvar m = 0; m < NQ; m++) begin : g_q
        logic msg_hit;
        assign msg_hit = (wi == W_MSG + m);

        // R3: count never exceeds depth
        p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[m] <= CW'(DEPTH));

        // R4: write to a full queue without a read is dropped
        p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && wr_en && !rd_en && msg_hit && q_cnt[m] == CW'(DEPTH))
            |=> $stable(q_cnt[m]));

        // R4: read of an empty queue leaves it empty
        p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && rd_en && !wr_en && msg_hit && q_cnt[m] == '0)
            |=> (q_cnt[m] == '0));

        // R10: simultaneous push and pop on a non-empty queue keeps the count
        p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && wr_en && rd_en && msg_hit && q_cnt[m] != '0)
            |=> $stable(q_cnt[m]));

        for (genvar u = 0; u < NU; u++) begin : g_u
            // R5: a growing count means the new-message bit is set
            p_newmsg_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (q_cnt[m] > $past(q_cnt[m])) |-> ustat[u][2*m]);
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        // R7: status bits only fall through an ack write to this user's register
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && !(wr_en && wi == W_IRQ + 2 * u))
            |=> ((ustat[u] & $past(ustat[u])) == $past(ustat[u])));

        // R8: interrupt line follows enabled status one cycle later
        p_irq_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[u] == |($past(ustat[u]) & $past(uen[u])));
    end

    // R9: a soft reset cycle leaves queues and interrupt state cleared
    p_srst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q_cnt == '0 && ustat == '0 && uen == '0));
endmodule

bind ipc_mailbox mbox_checker #(
    .NQ(NQ), .DEPTH(DEPTH), .NU(NU), .AW(AW), .CW(CW), .NEV(NEV)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wr_en (bus_wr_en),
    .rd_en (bus_rd_en),
    .busy  (busy),
    .q_cnt (q_cnt),
    .ustat (ustat),
    .uen   (uen),
    .irq   (irq_out)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
    localparam int NQ = 4, DEPTH = 4, NU = 2, RST_LEN = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr_en, bus_rd_en;
    logic [31:0] bus_wdata, bus_rdata;
    logic [1:0]  irq_out;

    always #5 clk = ~clk;

    ipc_mailbox dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // behavioural reference model
    logic [31:0] mq [NQ][$];
    logic [7:0]  mstat [NU];
    logic [7:0]  men [NU];
    logic [1:0]  mirq;
    int          mbusy;
    int          checks = 0, errors = 0;
    bit          done = 0;

    function automatic logic [11:0] a_msg(int m);  return 12'(12'h040 + 4 * m); endfunction
    function automatic logic [11:0] a_full(int m); return 12'(12'h080 + 4 * m); endfunction
    function automatic logic [11:0] a_cnt(int m);  return 12'(12'h0C0 + 4 * m); endfunction
    function automatic logic [11:0] a_st(int u);   return 12'(12'h100 + 8 * u); endfunction
    function automatic logic [11:0] a_en(int u);   return 12'(12'h104 + 8 * u); endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [11:0] a);
        int w = int'(a[11:2]);
        if (w == 0) return 32'h12;
        if (w == 4) return (mbusy > 0) ? 32'h2 : 32'h0;
        if (w == 5) return (mbusy > 0) ? 32'h0 : 32'h1;
        for (int m = 0; m < NQ; m++) begin
            if (w == 16 + m) return (mq[m].size() > 0) ? mq[m][0] : 32'h0;
            if (w == 32 + m) return (mq[m].size() == DEPTH) ? 32'h1 : 32'h0;
            if (w == 48 + m) return 32'(mq[m].size());
        end
        for (int u = 0; u < NU; u++) begin
            if (w == 64 + 2 * u) return {24'h0, mstat[u]};
            if (w == 65 + 2 * u) return {24'h0, men[u]};
        end
        return 32'h0;
    endfunction

    task automatic model_update(bit we, bit re, logic [11:0] a, logic [31:0] wd);
        int w = int'(a[11:2]);
        logic [1:0] nirq;
        logic [7:0] ev = 8'h0;
        for (int u = 0; u < NU; u++) nirq[u] = |(mstat[u] & men[u]);
        if (mbusy > 0) begin
            for (int m = 0; m < NQ; m++) mq[m].delete();
            for (int u = 0; u < NU; u++) begin mstat[u] = 8'h0; men[u] = 8'h0; end
            mbusy--;
        end else begin
            for (int m = 0; m < NQ; m++) begin
                bit hit = (w == 16 + m);
                bit was_full = (mq[m].size() == DEPTH);
                bit pop_ok = re && hit && (mq[m].size() > 0);
                bit push_ok = we && hit && (!was_full || pop_ok);
                ev[2*m]   = push_ok;
                ev[2*m+1] = pop_ok && !push_ok && was_full;
                if (pop_ok) void'(mq[m].pop_front());
                if (push_ok) mq[m].push_back(wd);
            end
            for (int u = 0; u < NU; u++) begin
                if (we && w == 64 + 2 * u) mstat[u] = mstat[u] & ~wd[7:0];
                if (we && w == 65 + 2 * u) men[u] = wd[7:0];
                mstat[u] = mstat[u] | ev;
            end
            if (we && w == 4 && wd[1]) mbusy = RST_LEN;
        end
        mirq = nirq;
    endtask

    task automatic cyc(bit we, bit re, logic [11:0] a, logic [31:0] wd, string req);
        @(negedge clk);
        bus_wr_en = we; bus_rd_en = re; bus_addr = a; bus_wdata = wd;
        #4;
        if (re) check(req, "rdata", bus_rdata, exp_read(a));
        check("R8", "irq_out", {30'h0, irq_out}, {30'h0, mirq});
        model_update(we, re, a, wd);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string req); cyc(1, 0, a, d, req); endtask
    task automatic rd(logic [11:0] a, string req);                  cyc(0, 1, a, 32'h0, req); endtask
    task automatic idle(string req);                                cyc(0, 0, 12'h0, 32'h0, req); endtask
    task automatic wrrd(logic [11:0] a, logic [31:0] d, string req); cyc(1, 1, a, d, req); endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < NU; u++) begin mstat[u] = 8'h0; men[u] = 8'h0; end
        mirq = 2'b00; mbusy = 0;
        rst_n = 1'b0; bus_addr = '0; bus_wr_en = 0; bus_rd_en = 0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset state and identification
        rd(12'h000, "R11");
        rd(12'h020, "R11");
        rd(12'h010, "R9");
        rd(12'h014, "R1");
        for (int m = 0; m < NQ; m++) begin rd(a_cnt(m), "R1"); rd(a_full(m), "R1"); end
        for (int u = 0; u < NU; u++) begin rd(a_st(u), "R1"); rd(a_en(u), "R1"); end

        // R8: enables
        wr(a_en(0), 32'hFF, "R8");
        wr(a_en(1), 32'hAA, "R8");
        rd(a_en(1), "R8");

        // R2 / R5: push three into queue 0
        wr(a_msg(0), 32'h1111_0001, "R2");
        wr(a_msg(0), 32'h2222_0002, "R2");
        wr(a_msg(0), 32'h3333_0003, "R2");
        rd(a_cnt(0), "R3");
        rd(a_st(0), "R5");
        rd(a_st(1), "R5");
        idle("R8"); idle("R8");
        for (int i = 0; i < 3; i++) rd(a_msg(0), "R2");
        rd(a_msg(0), "R4");
        rd(a_cnt(0), "R4");

        // R7: write-1-to-clear
        wr(a_st(0), 32'h0, "R7");
        rd(a_st(0), "R7");
        wr(a_st(0), 32'h1, "R7");
        rd(a_st(0), "R7");
        idle("R8"); idle("R8");

        // R3 / R4 / R6: fill queue 1, overflow, free a slot
        for (int i = 0; i < DEPTH; i++) wr(a_msg(1), 32'hA000_0000 + 32'(i), "R3");
        rd(a_full(1), "R3");
        rd(a_cnt(1), "R3");
        wr(a_msg(1), 32'hDEAD_BEEF, "R4");
        rd(a_cnt(1), "R4");
        rd(a_msg(1), "R6");
        rd(a_full(1), "R3");
        rd(a_st(1), "R6");
        idle("R8"); idle("R8");

        // R10: simultaneous push and pop on a full queue, then on an empty one
        wr(a_msg(1), 32'hB000_0004, "R10");
        rd(a_full(1), "R10");
        wr(a_st(0), 32'hFF, "R7");
        wr(a_st(1), 32'hFF, "R7");
        wrrd(a_msg(1), 32'hC000_0005, "R10");
        rd(a_cnt(1), "R10");
        rd(a_st(1), "R10");
        rd(a_st(0), "R10");
        for (int i = 0; i < DEPTH; i++) rd(a_msg(1), "R10");
        wrrd(a_msg(2), 32'hE000_0006, "R10");
        rd(a_cnt(2), "R10");
        rd(a_msg(2), "R10");

        // R9: soft reset
        wr(a_cfg_dummy(), 32'h1, "R9");
        rd(12'h014, "R9");
        wr(a_msg(3), 32'h5, "R9");
        wr(a_msg(3), 32'h6, "R9");
        wr(12'h010, 32'h2, "R9");
        rd(12'h010, "R9");
        rd(12'h014, "R9");
        wr(a_msg(3), 32'h7, "R9");
        idle("R9");
        rd(12'h014, "R9");
        rd(12'h010, "R9");
        rd(a_cnt(3), "R9");
        rd(a_en(0), "R9");
        rd(a_st(0), "R9");
        idle("R8"); idle("R8");

        done = 1;
        summary();
        $finish;
    end

    function automatic logic [11:0] a_cfg_dummy(); return 12'h010; endfunction
endmodule